// File: doc/BRIEF.md
# Keyed System Control Register Bank

This block is the control and identification register set of a processor core module. A processor reaches it over a simple synchronous word-addressed bus, with separate read and write strobes and 32-bit data in each direction. It returns fixed identification and status words, and it holds two clock-setting words that change only while a 16-bit unlock key sits in a lock register. It also holds a control word that drives the boot-memory selection and a board LED and can request a system reset. Two flag words have separate set and clear addresses. A 32-bit counter advances at a fixed reference rate.

A window of read-only words exposes a memory-module description table, one byte per word. The byte that gives the installed memory size is derived from a parameter, and the same parameter sets size bits in the reset value of the memory-configuration word. Read data is registered: it appears one cycle after the read strobe and then holds. A read of an address that maps to nothing returns zero and raises an error indication in the same cycle as its data.

Top module: `sysctl_keyed_bank`

## Requirements
- R1: After reset, reads return: word 0 = 0x411A3001, word 1 = 0, word 2 (oscillator) = 0x01000048, word 3 (control) = 0, word 4 (status) = 0x00100000, word 7 (auxiliary oscillator) = 0x0007FEFF, word 8 (memory config) = 0x00011122 OR the size bits of R9, word 9 (init) = 0x00000112, words 12 and 14 = 0. Outputs are boot_flash_sel = 1, led_on = 0, reset_req = 0.
- R2: A write to word 5 (lock) keeps bits 15:0 of the data. A read of word 5 gives 0x0001A05F while the kept value is 0xA05F, and otherwise gives the kept value zero-extended.
- R3: Writes to word 2 and word 7 replace the whole register only while the lock holds 0xA05F. In any other case the write leaves the register unchanged.
- R4: The control word keeps only data bit 0 (LED) and bit 2 (boot memory is RAM). Bit 3 and all other bits read as zero. led_on equals bit 0, and boot_flash_sel equals the inverse of bit 2.
- R5: A write to word 3 with data bit 3 set makes reset_req high for exactly the one cycle after that write's clock edge. A write to word 3 with bit 3 clear leaves reset_req low.
- R6: A write to word 12 ORs the data into the flags word. A write to word 13 clears the flags bits that are set in the data. Words 14 and 15 do the same to a second flags word, which is read at word 14. Neither word is affected by the other word's addresses.
- R7: Words 8 and 9 take any 32-bit write and read it back unchanged.
- R8: Word 10 reads floor(N*REF_HZ/CLK_HZ) modulo 2^32, where N is the number of clock edges after reset released before the read edge. The value never advances by more than one per cycle.
- R9: Words 64..95 return table byte (word-64) in bits 7:0 with zero above. The nonzero bytes are: 0:128, 1:8, 2:4, 3:11, 4:9, 5:1, 6:64, 8:2, 9:0xA0, 10:0xA0, 13:8, 15:1, 16:0x0E, 17:4, 18:0x1C, 19:1, 20:2, 21:0x20, 22:0xC0, 27:0x30, 28:0x28, 29:0x30, 30:0x28. Byte 31 and the size bits depend on MEM_MB: MEM_MB>=256 gives 64 and 0x10; >=128 gives 32 and 0x0C; >=64 gives 16 and 0x08; >=32 gives 4 and 0x04; otherwise 2 and none. Words 96..127 read 0.
- R10: A read of any word outside words 0-5, 7-10, 12, 14, 32-35 and 64-127 returns 0 with bus_rerr = 1. Implemented reads give bus_rerr = 0. Words 32..35 read 0, and writes to them and to unmapped words change nothing.
- R11: bus_rdata and bus_rerr change one cycle after bus_rd. bus_rdata holds its value while no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Word address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rerr | output | 1 | Unmapped-read indication, valid with bus_rdata |
| boot_flash_sel | output | 1 | High when boot flash is mapped at address zero |
| led_on | output | 1 | LED drive |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
Several rules are checked on every cycle. These are the single-cycle width and write origin of the reset request, the lock gating of both clock-setting words, the key storage, the control-write effect on the boot and LED outputs, zero data on error reads, the holding of read data between reads, and the at-most-one step of the counter. The bench alone shows the values: it sweeps the whole word space against a model of every register and the description table, runs lock and unlock sequences, and walks the flag set and clear patterns. It also checks counter readings against the exact rate formula at several distinct cycle counts.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam logic [31:0] ID_VALUE      = 32'h411A_3001;
    localparam logic [31:0] STAT_VALUE    = 32'h0010_0000;
    localparam logic [31:0] OSC_RST       = 32'h0100_0048;
    localparam logic [31:0] AUX_RST       = 32'h0007_FEFF;
    localparam logic [31:0] MEMCFG_BASE   = 32'h0001_1122;
    localparam logic [31:0] INIT_RST      = 32'h0000_0112;
    localparam logic [15:0] UNLOCK_KEY    = 16'hA05F;
    localparam logic [31:0] LOCK_OPEN_VAL = 32'h0001_A05F;

    // word indices decoded by software
    localparam int W_IDENT     = 0;
    localparam int W_PROC      = 1;
    localparam int W_OSC       = 2;
    localparam int W_CTRL      = 3;
    localparam int W_STAT      = 4;
    localparam int W_LOCK      = 5;
    localparam int W_AUX       = 7;
    localparam int W_MEMCFG    = 8;
    localparam int W_INIT      = 9;
    localparam int W_REFCNT    = 10;
    localparam int W_FLAGS_SET = 12;
    localparam int W_FLAGS_CLR = 13;
    localparam int W_NVF_SET   = 14;
    localparam int W_NVF_CLR   = 15;
    localparam int W_VOLT_LO   = 32;
    localparam int W_VOLT_HI   = 35;

    // control word bit positions seen by software
    localparam int CB_LED   = 0;
    localparam int CB_REMAP = 2;
    localparam int CB_RESET = 3;

    typedef struct packed {
        logic remap_ram;
        logic led;
    } ctrl_t;

    typedef struct packed {
        logic        err;
        logic [31:0] data;
    } rd_rsp_t;

    function automatic logic [31:0] memcfg_size_bits(input int mem_mb);
        if (mem_mb >= 256)      return 32'h10;
        else if (mem_mb >= 128) return 32'h0C;
        else if (mem_mb >= 64)  return 32'h08;
        else if (mem_mb >= 32)  return 32'h04;
        else                    return 32'h00;
    endfunction

    function automatic logic [7:0] size_table_byte(input int mem_mb);
        if (mem_mb >= 256)      return 8'd64;
        else if (mem_mb >= 128) return 8'd32;
        else if (mem_mb >= 64)  return 8'd16;
        else if (mem_mb >= 32)  return 8'd4;
        else                    return 8'd2;
    endfunction

    function automatic logic [7:0] module_desc_byte(input logic [4:0] idx, input int mem_mb);
        case (idx)
            5'd0:  return 8'd128;
            5'd1:  return 8'd8;
            5'd2:  return 8'd4;
            5'd3:  return 8'd11;
            5'd4:  return 8'd9;
            5'd5:  return 8'd1;
            5'd6:  return 8'd64;
            5'd8:  return 8'd2;
            5'd9:  return 8'hA0;
            5'd10: return 8'hA0;
            5'd13: return 8'd8;
            5'd15: return 8'd1;
            5'd16: return 8'h0E;
            5'd17: return 8'd4;
            5'd18: return 8'h1C;
            5'd19: return 8'd1;
            5'd20: return 8'd2;
            5'd21: return 8'h20;
            5'd22: return 8'hC0;
            5'd27: return 8'h30;
            5'd28: return 8'h28;
            5'd29: return 8'h30;
            5'd30: return 8'h28;
            5'd31: return size_table_byte(mem_mb);
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/sysctl_refcnt.sv
module sysctl_refcnt #(
    parameter int CLK_HZ = 50_000_000,
    parameter int REF_HZ = 24_000_000,
    parameter int CNT_W  = 32
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] count
);
    // fractional rate: accumulate REF_HZ per clock, tick on crossing CLK_HZ
    localparam int ACC_W = $clog2(CLK_HZ) + 1;
    localparam logic [ACC_W-1:0] STEP  = ACC_W'(REF_HZ);
    localparam logic [ACC_W-1:0] LIMIT = ACC_W'(CLK_HZ);

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] acc_sum;
    logic             tick;

    always_comb begin
        acc_sum = acc + STEP;
        tick    = (acc_sum >= LIMIT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc   <= '0;
            count <= '0;
        end else begin
            acc   <= tick ? (acc_sum - LIMIT) : acc_sum;
            count <= count + {{(CNT_W-1){1'b0}}, tick};
        end
    end
endmodule

// File: rtl/sysctl_setclr_reg.sv
module sysctl_setclr_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)         q <= '0;
        else if (set_en) q <= q | wdata;
        else if (clr_en) q <= q & ~wdata;
    end
endmodule

// File: rtl/sysctl_desc_rom.sv
module sysctl_desc_rom
    import sysctl_pkg::*;
#(
    parameter int MEM_MB = 128
) (
    input  logic [4:0] idx,
    output logic [7:0] data
);
    always_comb data = module_desc_byte(idx, MEM_MB);
endmodule

// File: rtl/sysctl_keyed_bank.sv
module sysctl_keyed_bank
    import sysctl_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int MEM_MB = 128,
    parameter int CLK_HZ = 50_000_000,
    parameter int REF_HZ = 24_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rerr,
    output logic              boot_flash_sel,
    output logic              led_on,
    output logic              reset_req
);
    localparam int DESC_FIRST = 64;
    localparam int DESC_LIVE  = 32;
    localparam int DESC_LAST  = 127;
    localparam int N_FLAGS    = 2;
    localparam logic [31:0] MEMCFG_RST = MEMCFG_BASE | memcfg_size_bits(MEM_MB);

    logic [31:0] word_idx;
    assign word_idx = 32'(bus_addr);

    // register state
    logic [15:0] lock_q;
    logic [31:0] osc_q, aux_q, memcfg_q, init_q;
    ctrl_t       ctrl_q;
    logic [31:0] count_q;
    logic        unlocked;
    assign unlocked = (lock_q == UNLOCK_KEY);

    // write decode
    logic wr_osc, wr_ctrl, wr_lock, wr_aux, wr_memcfg, wr_init;
    always_comb begin
        wr_osc    = bus_wr && (word_idx == W_OSC);
        wr_ctrl   = bus_wr && (word_idx == W_CTRL);
        wr_lock   = bus_wr && (word_idx == W_LOCK);
        wr_aux    = bus_wr && (word_idx == W_AUX);
        wr_memcfg = bus_wr && (word_idx == W_MEMCFG);
        wr_init   = bus_wr && (word_idx == W_INIT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q    <= '0;
            osc_q     <= OSC_RST;
            aux_q     <= AUX_RST;
            memcfg_q  <= MEMCFG_RST;
            init_q    <= INIT_RST;
            ctrl_q    <= '0;
            reset_req <= 1'b0;
        end else begin
            if (wr_lock)              lock_q   <= bus_wdata[15:0];
            if (wr_osc && unlocked)   osc_q    <= bus_wdata;
            if (wr_aux && unlocked)   aux_q    <= bus_wdata;
            if (wr_memcfg)            memcfg_q <= bus_wdata;
            if (wr_init)              init_q   <= bus_wdata;
            if (wr_ctrl) begin
                ctrl_q.led       <= bus_wdata[CB_LED];
                ctrl_q.remap_ram <= bus_wdata[CB_REMAP];
            end
            reset_req <= wr_ctrl && bus_wdata[CB_RESET];
        end
    end

    assign led_on         = ctrl_q.led;
    assign boot_flash_sel = ~ctrl_q.remap_ram;

    // set/clear flag words: bank 0 volatile, bank 1 non-volatile
    logic [N_FLAGS-1:0] fl_set, fl_clr;
    logic [31:0]        fl_q [N_FLAGS];
    for (genvar g = 0; g < N_FLAGS; g++) begin : g_flags
        localparam int SET_W = (g == 0) ? W_FLAGS_SET : W_NVF_SET;
        localparam int CLR_W = (g == 0) ? W_FLAGS_CLR : W_NVF_CLR;
        assign fl_set[g] = bus_wr && (word_idx == SET_W);
        assign fl_clr[g] = bus_wr && (word_idx == CLR_W);
        sysctl_setclr_reg #(.W(32)) u_reg (
            .clk    (clk),
            .rst    (rst),
            .set_en (fl_set[g]),
            .clr_en (fl_clr[g]),
            .wdata  (bus_wdata),
            .q      (fl_q[g])
        );
    end

    sysctl_refcnt #(.CLK_HZ(CLK_HZ), .REF_HZ(REF_HZ), .CNT_W(32)) u_refcnt (
        .clk   (clk),
        .rst   (rst),
        .count (count_q)
    );

    logic [7:0] desc_byte;
    sysctl_desc_rom #(.MEM_MB(MEM_MB)) u_desc (
        .idx  (bus_addr[$clog2(DESC_LIVE)-1:0]),
        .data (desc_byte)
    );

    // read mux
    rd_rsp_t rsp;
    always_comb begin
        rsp = '{err: 1'b0, data: 32'h0};
        if (word_idx >= DESC_FIRST && word_idx <= DESC_LAST) begin
            if (word_idx < DESC_FIRST + DESC_LIVE) rsp.data = {24'h0, desc_byte};
        end else begin
            case (word_idx) inside
                W_IDENT:               rsp.data = ID_VALUE;
                W_PROC:                rsp.data = 32'h0;
                W_OSC:                 rsp.data = osc_q;
                W_CTRL:                rsp.data = {29'h0, ctrl_q.remap_ram, 1'b0, ctrl_q.led};
                W_STAT:                rsp.data = STAT_VALUE;
                W_LOCK:                rsp.data = unlocked ? LOCK_OPEN_VAL : {16'h0, lock_q};
                W_AUX:                 rsp.data = aux_q;
                W_MEMCFG:              rsp.data = memcfg_q;
                W_INIT:                rsp.data = init_q;
                W_REFCNT:              rsp.data = count_q;
                W_FLAGS_SET:           rsp.data = fl_q[0];
                W_NVF_SET:             rsp.data = fl_q[1];
                [W_VOLT_LO:W_VOLT_HI]: rsp.data = 32'h0;
                default:               rsp.err  = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
            bus_rerr  <= 1'b0;
        end else begin
            bus_rerr <= bus_rd && rsp.err;
            if (bus_rd) bus_rdata <= rsp.data;
        end
    end
endmodule

// File: rtl/sysctl_keyed_bank_chk.sv
module sysctl_keyed_bank_chk
    import sysctl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              bus_rerr,
    input logic              boot_flash_sel,
    input logic              led_on,
    input logic              reset_req,
    input logic [15:0]       lock_q,
    input logic [31:0]       osc_q,
    input logic [31:0]       aux_q,
    input logic [31:0]       count_q
);
    p_key_store_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(W_LOCK)) |=> lock_q == $past(bus_wdata[15:0]));

    p_osc_locked_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(W_OSC) && lock_q != UNLOCK_KEY) |=> $stable(osc_q));

    p_aux_locked_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(W_AUX) && lock_q != UNLOCK_KEY) |=> $stable(aux_q));

    p_osc_open_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(W_OSC) && lock_q == UNLOCK_KEY) |=> osc_q == $past(bus_wdata));

    p_ctrl_outputs_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(W_CTRL)) |=>
        (boot_flash_sel == !$past(bus_wdata[CB_REMAP]) && led_on == $past(bus_wdata[CB_LED])));

    p_pulse_single_r5: assert property (@(posedge clk) disable iff (rst)
        reset_req |=> !reset_req);

    p_pulse_source_r5: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> $past(bus_wr && bus_addr == ADDR_W'(W_CTRL) && bus_wdata[CB_RESET]));

    p_cnt_step_r8: assert property (@(posedge clk) disable iff (rst)
        (count_q == $past(count_q)) || (count_q == $past(count_q) + 32'd1));

    p_err_zero_r10: assert property (@(posedge clk) disable iff (rst)
        bus_rerr |-> bus_rdata == 32'h0);

    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));
endmodule

bind sysctl_keyed_bank sysctl_keyed_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .bus_addr       (bus_addr),
    .bus_rd         (bus_rd),
    .bus_wr         (bus_wr),
    .bus_wdata      (bus_wdata),
    .bus_rdata      (bus_rdata),
    .bus_rerr       (bus_rerr),
    .boot_flash_sel (boot_flash_sel),
    .led_on         (led_on),
    .reset_req      (reset_req),
    .lock_q         (lock_q),
    .osc_q          (osc_q),
    .aux_q          (aux_q),
    .count_q        (count_q)
);

// File: tb/sysctl_keyed_bank_tb.sv
`timescale 1ns/1ps
module sysctl_keyed_bank_tb;
    localparam int ADDR_W = 8;
    localparam int MEM_MB = 128;
    localparam int CLK_HZ = 50_000_000;
    localparam int REF_HZ = 24_000_000;
    localparam int WORDS  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_rd = 1'b0;
    logic              bus_wr = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_rerr;
    logic              boot_flash_sel, led_on, reset_req;

    sysctl_keyed_bank #(.ADDR_W(ADDR_W), .MEM_MB(MEM_MB), .CLK_HZ(CLK_HZ), .REF_HZ(REF_HZ)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rerr(bus_rerr),
        .boot_flash_sel(boot_flash_sel), .led_on(led_on), .reset_req(reset_req)
    );

    always #10 clk = ~clk;

    longint unsigned cyc;
    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // reference model state
    logic [15:0] m_lock;
    logic [31:0] m_osc, m_aux, m_memcfg, m_init, m_ctrl, m_flags, m_nvf;

    function automatic logic [31:0] size_bits();
        if (MEM_MB >= 256) return 32'h10;
        if (MEM_MB >= 128) return 32'h0C;
        if (MEM_MB >= 64)  return 32'h08;
        if (MEM_MB >= 32)  return 32'h04;
        return 32'h0;
    endfunction

    function automatic logic [7:0] table_byte(input int k);
        logic [7:0] t [32];
        for (int i = 0; i < 32; i++) t[i] = 8'h0;
        t[0] = 128; t[1] = 8; t[2] = 4; t[3] = 11; t[4] = 9; t[5] = 1; t[6] = 64;
        t[8] = 2; t[9] = 8'hA0; t[10] = 8'hA0; t[13] = 8; t[15] = 1; t[16] = 8'h0E;
        t[17] = 4; t[18] = 8'h1C; t[19] = 1; t[20] = 2; t[21] = 8'h20; t[22] = 8'hC0;
        t[27] = 8'h30; t[28] = 8'h28; t[29] = 8'h30; t[30] = 8'h28;
        if (MEM_MB >= 256)     t[31] = 64;
        else if (MEM_MB >= 128) t[31] = 32;
        else if (MEM_MB >= 64)  t[31] = 16;
        else if (MEM_MB >= 32)  t[31] = 4;
        else                    t[31] = 2;
        return t[k];
    endfunction

    // {err, data} expected for word a read with c edges counted before the read edge
    function automatic logic [32:0] expect_word(input int a, input longint unsigned c);
        longint unsigned ticks;
        ticks = (c * longint'(REF_HZ)) / longint'(CLK_HZ);
        if (a >= 64 && a < 96)  return {1'b0, 24'h0, table_byte(a - 64)};
        if (a >= 96 && a < 128) return 33'h0;
        if (a >= 32 && a <= 35) return 33'h0;
        case (a)
            0:  return {1'b0, 32'h411A3001};
            1:  return 33'h0;
            2:  return {1'b0, m_osc};
            3:  return {1'b0, m_ctrl};
            4:  return {1'b0, 32'h00100000};
            5:  return {1'b0, (m_lock == 16'hA05F) ? 32'h0001A05F : {16'h0, m_lock}};
            7:  return {1'b0, m_aux};
            8:  return {1'b0, m_memcfg};
            9:  return {1'b0, m_init};
            10: return {1'b0, ticks[31:0]};
            12: return {1'b0, m_flags};
            14: return {1'b0, m_nvf};
            default: return {1'b1, 32'h0};
        endcase
    endfunction

    function automatic string tag_of(input int a);
        if (a == 10) return "R8";
        if (a >= 64 && a < 128) return "R9";
        if (a == 2 || a == 7) return "R3";
        if (a == 5) return "R2";
        if (a == 12 || a == 14) return "R6";
        if (a == 8 || a == 9) return "R7";
        if (a == 3) return "R4";
        if ((a >= 32 && a <= 35) || a == 6 || a == 11 || a == 13 || a == 15 || a > 15) return "R10";
        return "R1";
    endfunction

    task automatic model_write(input int a, input logic [31:0] d);
        case (a)
            2:  if (m_lock == 16'hA05F) m_osc = d;
            3:  m_ctrl = {29'h0, d[2], 1'b0, d[0]};
            5:  m_lock = d[15:0];
            7:  if (m_lock == 16'hA05F) m_aux = d;
            8:  m_memcfg = d;
            9:  m_init = d;
            12: m_flags = m_flags | d;
            13: m_flags = m_flags & ~d;
            14: m_nvf = m_nvf | d;
            15: m_nvf = m_nvf & ~d;
            default: ;
        endcase
    endtask

    // tasks start and end at a falling edge
    task automatic bus_write(input int a, input logic [31:0] d);
        bus_addr  = ADDR_W'(a);
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic bus_read(input int a, output logic [31:0] d, output logic e, output longint unsigned c);
        bus_addr = ADDR_W'(a);
        bus_rd   = 1'b1;
        c        = cyc;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
        e = bus_rerr;
    endtask

    task automatic read_check(input int a, input string req);
        logic [31:0] d;
        logic e;
        longint unsigned c;
        logic [32:0] x;
        bus_read(a, d, e, c);
        x = expect_word(a, c);
        check(req, $sformatf("data word %0d", a), d, x[31:0]);
        check(req, $sformatf("err word %0d", a), {31'h0, e}, {31'h0, x[32]});
    endtask

    task automatic sweep();
        for (int a = 0; a < WORDS; a++) read_check(a, tag_of(a));
    endtask

    initial begin
        #(20.0 * 200000);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        m_lock = 16'h0; m_osc = 32'h01000048; m_aux = 32'h0007FEFF;
        m_memcfg = 32'h00011122 | size_bits(); m_init = 32'h00000112;
        m_ctrl = 32'h0; m_flags = 32'h0; m_nvf = 32'h0;

        repeat (3) @(negedge clk);
        // R1: output reset state
        check("R1", "boot_flash_sel at reset", {31'h0, boot_flash_sel}, 32'h1);
        check("R1", "led_on at reset", {31'h0, led_on}, 32'h0);
        check("R1", "reset_req at reset", {31'h0, reset_req}, 32'h0);
        check("R11", "rdata at reset", bus_rdata, 32'h0);
        rst = 1'b0;

        // full-space sweep of reset values, table, errors, counter
        sweep();

        // R11: data holds with no read
        read_check(0, "R1");
        held = bus_rdata;
        repeat (3) @(negedge clk);
        check("R11", "rdata hold", bus_rdata, held);
        check("R11", "rerr clears after read", {31'h0, bus_rerr}, 32'h0);

        // R3: locked writes ignored
        bus_write(2, 32'hDEAD0001);
        bus_write(7, 32'hDEAD0007);
        read_check(2, "R3");
        read_check(7, "R3");
        // R2: key storage and readback
        bus_write(5, 32'h1234A05F);
        read_check(5, "R2");
        bus_write(2, 32'hCAFE0002);
        bus_write(7, 32'h00ABCDEF);
        read_check(2, "R3");
        read_check(7, "R3");
        bus_write(5, 32'hFFFFA05E);
        read_check(5, "R2");
        bus_write(7, 32'h00000001);
        bus_write(2, 32'h00000002);
        read_check(7, "R3");
        read_check(2, "R3");

        // R4/R5: control word and reset pulse
        bus_write(3, 32'hFFFFFFFF);
        check("R5", "reset_req after write", {31'h0, reset_req}, 32'h1);
        check("R4", "led_on set", {31'h0, led_on}, 32'h1);
        check("R4", "boot_flash_sel cleared", {31'h0, boot_flash_sel}, 32'h0);
        @(negedge clk);
        check("R5", "reset_req one cycle", {31'h0, reset_req}, 32'h0);
        read_check(3, "R4");
        bus_write(3, 32'h00000001);
        check("R5", "no pulse without bit 3", {31'h0, reset_req}, 32'h0);
        check("R4", "boot_flash_sel back", {31'h0, boot_flash_sel}, 32'h1);
        bus_write(3, 32'h0000000C);
        check("R5", "pulse with bit 3", {31'h0, reset_req}, 32'h1);
        check("R4", "led_on cleared", {31'h0, led_on}, 32'h0);
        read_check(3, "R4");

        // R6: set/clear flags
        bus_write(12, 32'h0000F0F0);
        bus_write(12, 32'h00000F00);
        read_check(12, "R6");
        bus_write(13, 32'h000000F0);
        read_check(12, "R6");
        read_check(14, "R6");
        bus_write(14, 32'h80000001);
        bus_write(15, 32'h00000001);
        read_check(14, "R6");
        read_check(12, "R6");

        // R7: plain read/write words
        bus_write(8, 32'hA5A55A5A);
        bus_write(9, 32'h0F0F1234);
        read_check(8, "R7");
        read_check(9, "R7");

        // R10: writes to voltage and unmapped words do nothing
        bus_write(33, 32'hFFFFFFFF);
        bus_write(6, 32'hFFFFFFFF);
        bus_write(200, 32'hFFFFFFFF);
        read_check(33, "R10");
        read_check(6, "R10");

        // R8: counter at several distances
        read_check(10, "R8");
        repeat (1000) @(negedge clk);
        read_check(10, "R8");
        repeat (4321) @(negedge clk);
        read_check(10, "R8");

        // final sweep with the modified state
        sweep();

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule